// File: doc/BRIEF.md
# Rollover Periodic Interrupt Generator

This block turns the increment strobes of a calendar clock's counters into a periodic interrupt for a host processor. Six counter sources (for example hundredths, seconds, minutes, hours, days and months) each give a one-cycle strobe when they advance. A host-writable control register selects which of these strobes may raise an interrupt. When a selected strobe arrives, a single pending flag is set and an active-low interrupt pin is asserted. Both stay that way until the host clears the flag.

The interrupt follows the counter's own advance and not a separate divider. Because of this, the first interrupt after enabling a source can come sooner than one full period, and each later one is spaced exactly one period apart. During battery-backed standby, a backup-mode enable input decides whether the selected sources still have any effect. The upper two bits of the control register are plain storage.

Top module: `rollover_irq_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control register is cleared to 0x00, `pend` is cleared to 0 and `irq_n` reads 1.
- R2: A write (`wr_en`=1) loads all eight bits of `wr_data` into the control register at that clock edge, and `rd_data` returns the stored value from then on.
- R3: Control bit i (i = 0..5) enables source `tick[i]`. A `tick[i]` pulse at an edge where bit i is effectively enabled sets `pend` to 1 at that edge.
- R4: A tick on a source whose control bit is 0 does not set `pend`.
- R5: When control bits 5..0 are all zero, no tick sets `pend`, and `irq_n` stays 1.
- R6: While `standby`=1 and `bkup_en`=0, the effective enable mask is all zero, so ticks do not set `pend` and `irq_n` stays 1. While `standby`=1 and `bkup_en`=1, the stored bits apply as normal.
- R7: `irq_n` is 0 exactly when `pend`=1 and at least one bit of the effective enable mask is 1.
- R8: `pend` holds at 1 until a clock edge with `clr`=1 and no enabled tick. When `clr` and an enabled tick arrive at the same edge, the tick wins and `pend` stays 1.
- R9: Control bits 7 and 6 are storage only. With only those bits set, ticks on any source leave `pend` at 0.
- R10: At an edge that both writes the register and carries a tick, the tick is judged against the register value from before the write.
- R11: Once a source with a fixed tick period P is enabled, the first interrupt comes no later than P cycles after enabling, and each later interrupt comes exactly P cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Data for the control register |
| rd_data | output | 8 | Current control register contents |
| tick | input | 6 | One-cycle increment strobes, one per clock counter |
| standby | input | 1 | Device is in battery-backed standby |
| bkup_en | input | 1 | Backup-mode gate for the enables during standby |
| clr | input | 1 | Clears the pending flag (write-one-to-clear) |
| pend | output | 1 | Periodic interrupt pending flag |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
A tick or write applied before a clock edge shows up on `pend` and `rd_data` right after that edge, which is one register stage. `irq_n` is combinational from `pend`, the stored enables and the mode inputs, so it responds at once to a change in `standby` or `bkup_en`. The bench drives inputs just after the falling edge, and a behavioural model updates at the rising edge from the same inputs. At every following falling edge all three outputs are compared with the model, so each result is checked in the cycle it is due. Directed checks at the same sampling point cover the write/tick collision, the clear/tick collision and the spacing of periodic interrupts.

// File: rtl/rtc_pirq_pkg.sv
// Package: shared sizes and types for the rollover periodic interrupt block.
// Assumes six counter sources and an 8-bit host control register.
package rtc_pirq_pkg;
    localparam int unsigned NUM_SRC = 6;
    localparam int unsigned REG_W   = 8;
    typedef logic [NUM_SRC-1:0] src_mask_t;
    typedef logic [REG_W-1:0]   ctrl_word_t;
endpackage

// File: rtl/pirq_ctrl_reg.sv
// Module: holds the host control register and derives the effective enable
// mask. During standby the backup gate decides whether the stored enables
// count. Assumes REG_W >= NUM_SRC; any bits above NUM_SRC are storage only.
module pirq_ctrl_reg #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned REG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               standby,
    input  logic               bkup_en,
    output logic [REG_W-1:0]   ctrl_q,
    output logic [NUM_SRC-1:0] eff_mask
);
    logic gate_open;

    // Purpose: load the control register on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_data;
    end

    // Purpose: the backup gate overrides the enables only while in standby.
    always_comb gate_open = !standby || bkup_en;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
        // Purpose: one gated enable per counter source.
        always_comb eff_mask[i] = ctrl_q[i] && gate_open;
    end
endmodule

// File: rtl/pirq_match.sv
// Module: combines rollover strobes with the effective enables.
// Assumes each tick is a single-cycle strobe.
module pirq_match #(
    parameter int unsigned NUM_SRC = 6
) (
    input  logic [NUM_SRC-1:0] tick,
    input  logic [NUM_SRC-1:0] eff_mask,
    output logic               hit,
    output logic               any_en
);
    // Purpose: any enabled rollover this cycle, and whether any source is armed.
    always_comb begin
        hit    = |(tick & eff_mask);
        any_en = |eff_mask;
    end
endmodule

// File: rtl/pirq_status.sv
// Module: sticky pending flag, write-one-to-clear. A set at the same edge
// as a clear wins, so no event is lost.
module pirq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic pend
);
    // Purpose: set on an enabled rollover, clear on a host request.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (hit) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end
endmodule

// File: rtl/rollover_irq_gen.sv
// Module: top of the rollover periodic interrupt generator. Assumes the tick
// strobes are synchronous to clk and each lasts one cycle per counter advance.
module rollover_irq_gen #(
    parameter int unsigned NUM_SRC = rtc_pirq_pkg::NUM_SRC,
    parameter int unsigned REG_W   = rtc_pirq_pkg::REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_SRC-1:0] tick,
    input  logic               standby,
    input  logic               bkup_en,
    input  logic               clr,
    output logic               pend,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] eff_mask;
    logic               hit;
    logic               any_en;

    pirq_ctrl_reg #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .standby(standby), .bkup_en(bkup_en),
        .ctrl_q(rd_data), .eff_mask(eff_mask)
    );

    pirq_match #(.NUM_SRC(NUM_SRC)) match_i (
        .tick(tick), .eff_mask(eff_mask), .hit(hit), .any_en(any_en)
    );

    pirq_status stat_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .pend(pend)
    );

    // Purpose: drive the pin low while a pending flag has an armed source.
    always_comb irq_n = !(pend && any_en);
endmodule

// File: rtl/pirq_chk.sv
// Module: assertion checker bound to rollover_irq_gen. Works from the
// top-level ports only.
module pirq_chk #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned REG_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic [REG_W-1:0]   rd_data,
    input logic [NUM_SRC-1:0] tick,
    input logic               standby,
    input logic               bkup_en,
    input logic               clr,
    input logic               pend,
    input logic               irq_n
);
    logic [NUM_SRC-1:0] ref_mask;
    logic               ref_hit;

    // Purpose: enables as seen from the ports, for use in the properties.
    always_comb begin
        ref_mask = (standby && !bkup_en) ? '0 : rd_data[NUM_SRC-1:0];
        ref_hit  = |(tick & ref_mask);
    end

    // R2
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) && $past(rst_n) |-> rd_data == $past(wr_data));

    // R3
    set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hit |=> pend);

    // R4
    rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend && !ref_hit |=> !pend);

    // R5
    all_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[NUM_SRC-1:0] == '0) |-> irq_n);

    // R6
    standby_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby && !bkup_en |-> irq_n);

    // R7
    pin_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(pend && (|ref_mask)));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !clr |=> pend);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !ref_hit |=> !pend);
endmodule

bind rollover_irq_gen pirq_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .standby(standby), .bkup_en(bkup_en),
    .clr(clr), .pend(pend), .irq_n(irq_n)
);

// File: tb/rollover_irq_gen_tb_top.sv
// Bench: behavioural reference model compared on every falling edge, plus
// directed checks for each requirement.
module rollover_irq_gen_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [5:0] tick = 0;
    logic       standby = 0;
    logic       bkup_en = 0;
    logic       clr = 0;
    logic       pend;
    logic       irq_n;

    logic       nxt_sb = 0;
    logic       nxt_bk = 0;

    int nchk = 0;
    int nerr = 0;
    bit run_cmp = 0;
    bit done = 0;

    logic [7:0] m_en = 0;
    logic       m_pend = 0;

    rollover_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .standby(standby), .bkup_en(bkup_en),
        .clr(clr), .pend(pend), .irq_n(irq_n)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [5:0] meff(logic [7:0] en, logic sb, logic bk);
        return (sb && !bk) ? 6'd0 : en[5:0];
    endfunction

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: updated at the rising edge from the inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pend = 0;
        end else begin
            if (|(tick & meff(m_en, standby, bkup_en))) m_pend = 1;
            else if (clr) m_pend = 0;
            if (wr_en) m_en = wr_data;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            chk("R2 rd_data", rd_data, m_en);
            chk("R3 pend", pend, m_pend);
            chk("R7 irq_n", irq_n, !(m_pend && (|meff(m_en, standby, bkup_en))));
        end
    end

    // One cycle: drive just after the falling edge, return at the next falling edge.
    task automatic step(logic [5:0] t, logic w, logic [7:0] d, logic c);
        #1;
        tick = t; wr_en = w; wr_data = d; clr = c;
        standby = nxt_sb; bkup_en = nxt_bk;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int rises[$];
        bit do_clr;
        @(negedge clk);
        rst_n = 0;
        step(6'h3F, 1, 8'hFF, 0);
        step(6'h3F, 1, 8'hFF, 0);
        // R1: reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 pend", pend, 0);
        chk("R1 irq_n", irq_n, 1);
        #1 rst_n = 1;
        run_cmp = 1;

        // R2: full write and readback
        step(0, 1, 8'hA5, 0);
        chk("R2 write A5", rd_data, 8'hA5);
        // R5: all source enables zero
        step(0, 1, 8'h00, 0);
        step(6'h3F, 0, 0, 0);
        step(6'h3F, 0, 0, 0);
        chk("R5 pend", pend, 0);
        chk("R5 irq_n", irq_n, 1);
        // R9: storage bits only
        step(0, 1, 8'hC0, 0);
        step(6'h3F, 0, 0, 0);
        chk("R9 pend", pend, 0);
        chk("R9 rd_data", rd_data, 8'hC0);
        // R4: disabled sources
        step(0, 1, 8'h01, 0);
        step(6'h3E, 0, 0, 0);
        chk("R4 pend", pend, 0);
        // R3: enabled source sets flag
        step(6'h01, 0, 0, 0);
        chk("R3 pend", pend, 1);
        chk("R7 irq_n low", irq_n, 0);
        // R8: sticky, clear, set wins over clear
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk("R8 sticky", pend, 1);
        step(0, 0, 0, 1);
        chk("R8 cleared", pend, 0);
        step(6'h01, 0, 0, 0);
        step(6'h01, 0, 0, 1);
        chk("R8 set wins", pend, 1);
        // R7: disarming with flag pending releases pin
        step(0, 1, 8'h00, 0);
        chk("R7 pend kept", pend, 1);
        chk("R7 pin released", irq_n, 1);
        step(0, 1, 8'h20, 0);
        chk("R7 pin re-armed", irq_n, 0);
        step(0, 0, 0, 1);
        chk("R8 clear2", pend, 0);
        // R6: standby gating
        step(0, 1, 8'h3F, 0);
        nxt_sb = 1; nxt_bk = 0;
        step(6'h3F, 0, 0, 0);
        chk("R6 gated pend", pend, 0);
        nxt_bk = 1;
        step(6'h04, 0, 0, 0);
        chk("R6 backup pend", pend, 1);
        chk("R6 backup pin", irq_n, 0);
        nxt_bk = 0;
        step(0, 0, 0, 0);
        chk("R6 pin gated", irq_n, 1);
        nxt_sb = 0;
        step(0, 0, 0, 1);
        chk("R6 clear", pend, 0);
        // R10: write and tick at the same edge use the old enables
        step(0, 1, 8'h00, 0);
        step(6'h3F, 1, 8'h3F, 0);
        chk("R10 old off", pend, 0);
        step(6'h3F, 1, 8'h00, 0);
        chk("R10 old on", pend, 1);
        step(0, 0, 0, 1);
        // R11: periodic spacing, period 8 on source 1, enabled at cycle 2
        do_clr = 0;
        for (int c = 0; c < 41; c++) begin
            step((c % 8 == 5) ? 6'h02 : 6'h00, c == 2, 8'h02, do_clr);
            do_clr = 0;
            if (pend) begin
                rises.push_back(c);
                do_clr = 1;
            end
        end
        chk("R11 count", rises.size(), 5);
        if (rises.size() > 0) chk("R11 first early", (rises[0] - 2) < 8, 1);
        for (int k = 1; k < rises.size(); k++)
            chk("R11 spacing", rises[k] - rises[k-1], 8);
        step(0, 0, 0, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule